// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits between a serial memory's bus controller and its byte array. During a write transfer, the controller hands it data bytes one at a time. Each byte comes with a 5-bit position inside a 32-byte page. The block keeps the bytes and remembers which positions were filled. When the transfer ends, the controller raises a commit request together with the 8-bit page number. The block then copies the filled positions into the array, writing them at the 13-bit address formed from the page number and the position.

The commit is self-timed. Busy rises on the clock after the request and stays high for a parameterised number of clock ticks, which model the nonvolatile programming time. While busy is high, the block ignores loads and further commit requests. A commit request with no bytes filled, as in an address-only transfer, does nothing.

When the write-protect input is high at the commit request and the page falls in the top quarter of the array, the block discards the commit. It writes nothing to the array but still runs busy for the full duration, so acknowledge polling sees the same timing.

Top module: `page_commit_buf`

## Requirements
- R1: After reset, busy is low and no array write strobe is issued.
- R2: While busy is low, a load strobe stores the data byte at the 5-bit position given with it and marks that position as filled.
- R3: A commit request while busy is low, with at least one position filled, raises busy on the next clock. During busy, it issues one array write per filled position, in ascending position order, at address {page[7:0], position[4:0]}, and issues none for unfilled positions.
- R4: When the same position is loaded more than once before a commit, only the last value loaded at that position is written.
- R5: Busy stays high for exactly CYCLE_TICKS consecutive clock cycles after a commit starts.
- R6: All filled marks clear when busy falls, so the next commit writes only the positions loaded after that point.
- R7: Load strobes and commit requests that arrive while busy is high have no effect.
- R8: A commit request with no position filled leaves busy low and issues no array write.
- R9: If write-protect is high at the commit request and page bits [7:6] are both 1 (addresses 1800h to 1FFFh), the block issues no array write but still holds busy high for CYCLE_TICKS cycles.
- R10: With write-protect low, any page is written. With write-protect high, pages whose bits [7:6] are not both 1 are written normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Byte-load strobe |
| load_idx | input | 5 | Position of the byte inside the page |
| load_data | input | 8 | Byte to store |
| page_sel | input | 8 | Page number, sampled with the commit request |
| commit_req | input | 1 | End-of-transfer commit request |
| wp | input | 1 | Write-protect input, sampled with the commit request |
| busy | output | 1 | High during the timed commit cycle |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 13 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The bench fills pages in several ways: fully, sparsely, and with repeated positions. A design that ignored the filled mask would write stale or zero bytes. A design that kept the first value instead of the last would write the wrong data.

A commit on a protected page must still produce a full busy pulse. A design that skipped the timer for a dropped commit would shorten the busy pulse. A design that ignored write-protect would leak writes into the top quarter.

The bench also loads bytes and repeats the commit request while busy is high. It then commits a single byte, which exposes two faults: a mask that never clears, and a block that accepts input during busy. An empty commit must leave busy low, because an address-only transfer would otherwise stall the bus side.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam int PCB_PAGE_W = 8;
  localparam int PCB_IDX_W  = 5;
  localparam int PCB_DATA_W = 8;

  // Top quarter of the array is locked when write-protect is high.
  function automatic logic pcb_locked(input logic wp_i, input logic [1:0] page_top);
    return wp_i && (page_top == 2'b11);
  endfunction

  // Flat array address from page and in-page position.
  function automatic logic [PCB_PAGE_W+PCB_IDX_W-1:0] pcb_flat(
      input logic [PCB_PAGE_W-1:0] page, input logic [PCB_IDX_W-1:0] idx);
    return {page, idx};
  endfunction
endpackage

// File: rtl/pcb_store.sv
module pcb_store #(
  parameter int IDX_W  = 5,
  parameter int DATA_W = 8,
  localparam int NBYTES = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_filled,
  output logic              any_filled
);
  logic [DATA_W-1:0] data_q [NBYTES];
  logic [NBYTES-1:0] fill_q;

  always_ff @(posedge clk) begin
    if (wr_en) data_q[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_q <= '0;
    end else if (clr) begin
      fill_q <= '0;
    end else begin
      for (int i = 0; i < NBYTES; i++) begin
        if (wr_en && (wr_idx == IDX_W'(i))) fill_q[i] <= 1'b1;
      end
    end
  end

  assign rd_data    = data_q[rd_idx];
  assign rd_filled  = fill_q[rd_idx];
  assign any_filled = |fill_q;
endmodule

// File: rtl/pcb_seq.sv
module pcb_seq #(
  parameter int IDX_W       = 5,
  parameter int CYCLE_TICKS = 1000,
  localparam int CNT_W  = $clog2(CYCLE_TICKS + 1),
  localparam int NBYTES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             scan_on,
  output logic [IDX_W-1:0] scan_idx,
  output logic             finish
);
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      left_q   <= '0;
      scan_on  <= 1'b0;
      scan_idx <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      left_q   <= CNT_W'(CYCLE_TICKS - 1);
      scan_on  <= 1'b1;
      scan_idx <= '0;
    end else begin
      if (busy) begin
        if (left_q == '0) busy <= 1'b0;
        else              left_q <= left_q - 1'b1;
      end
      if (scan_on) begin
        if (scan_idx == IDX_W'(NBYTES - 1)) scan_on <= 1'b0;
        scan_idx <= scan_idx + 1'b1;
      end
    end
  end

  assign finish = busy && (left_q == '0);
endmodule

// File: rtl/page_commit_buf.sv
module page_commit_buf
  import pcb_pkg::*;
#(
  parameter int PAGE_W      = PCB_PAGE_W,
  parameter int IDX_W       = PCB_IDX_W,
  parameter int DATA_W      = PCB_DATA_W,
  parameter int CYCLE_TICKS = 1000,
  localparam int ADDR_W = PAGE_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [IDX_W-1:0]  load_idx,
  input  logic [DATA_W-1:0] load_data,
  input  logic [PAGE_W-1:0] page_sel,
  input  logic              commit_req,
  input  logic              wp,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  // Named internal events (used by the bound checker)
  logic              load_take;
  logic              commit_start;
  logic              any_valid;
  logic              cycle_end;
  logic              scan_on;
  logic [IDX_W-1:0]  scan_idx;
  logic [DATA_W-1:0] rd_data;
  logic              rd_filled;
  logic [PAGE_W-1:0] page_q;
  logic              drop_q;

  assign load_take    = load_en && !busy;
  assign commit_start = commit_req && !busy && any_valid;

  pcb_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (load_take),
    .wr_idx     (load_idx),
    .wr_data    (load_data),
    .clr        (cycle_end),
    .rd_idx     (scan_idx),
    .rd_data    (rd_data),
    .rd_filled  (rd_filled),
    .any_filled (any_valid)
  );

  pcb_seq #(.IDX_W(IDX_W), .CYCLE_TICKS(CYCLE_TICKS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (commit_start),
    .busy     (busy),
    .scan_on  (scan_on),
    .scan_idx (scan_idx),
    .finish   (cycle_end)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= '0;
      drop_q <= 1'b0;
    end else if (commit_start) begin
      page_q <= page_sel;
      drop_q <= pcb_locked(wp, page_sel[PAGE_W-1 -: 2]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we    <= scan_on && rd_filled && !drop_q;
      mem_addr  <= {page_q, scan_idx};
      mem_wdata <= rd_data;
    end
  end
endmodule

// File: rtl/pcb_checker.sv
module pcb_checker #(
  parameter int PAGE_W      = 8,
  parameter int IDX_W       = 5,
  parameter int CYCLE_TICKS = 1000
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     commit_req,
  input logic                     wp,
  input logic [PAGE_W-1:0]        page_sel,
  input logic                     busy,
  input logic                     mem_we,
  input logic [PAGE_W+IDX_W-1:0]  mem_addr,
  input logic                     commit_start,
  input logic                     any_valid
);
  logic [31:0]       busy_len;
  logic [PAGE_W-1:0] ck_page;
  logic              ck_lock;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_len <= '0;
      ck_page  <= '0;
      ck_lock  <= 1'b0;
    end else begin
      busy_len <= busy ? busy_len + 1 : 32'd0;
      if (commit_start) begin
        ck_page <= page_sel;
        ck_lock <= wp && (page_sel[PAGE_W-1 -: 2] == 2'b11);
      end
    end
  end

  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    commit_start |=> busy); // R3
  AST_WE_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[PAGE_W+IDX_W-1:IDX_W] == ck_page)); // R3
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == CYCLE_TICKS)); // R5
  AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy); // R5
  AST_MASK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !any_valid); // R6
  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_req && !busy && !any_valid) |=> !busy); // R8
  AST_LOCK_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && busy) |-> !ck_lock); // R9
endmodule

bind page_commit_buf pcb_checker #(
  .PAGE_W(PAGE_W), .IDX_W(IDX_W), .CYCLE_TICKS(CYCLE_TICKS)
) u_pcb_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .commit_req   (commit_req),
  .wp           (wp),
  .page_sel     (page_sel),
  .busy         (busy),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .commit_start (commit_start),
  .any_valid    (any_valid)
);

// File: tb/test_page_commit_buf.sv
`timescale 1ns/1ps
module test_page_commit_buf;
  localparam int CYC = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_en = 1'b0;
  logic [4:0]  load_idx = '0;
  logic [7:0]  load_data = '0;
  logic [7:0]  page_sel = '0;
  logic        commit_req = 1'b0;
  logic        wp = 1'b0;
  logic        busy;
  logic        mem_we;
  logic [12:0] mem_addr;
  logic [7:0]  mem_wdata;

  int checks = 0;
  int errors = 0;

  logic [7:0]  m_data [32];
  logic [31:0] m_fill = '0;
  logic [20:0] exp_q [$];

  always #5 clk = ~clk;

  page_commit_buf #(.CYCLE_TICKS(CYC)) i_page_commit_buf (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_idx(load_idx),
    .load_data(load_data), .page_sel(page_sel), .commit_req(commit_req),
    .wp(wp), .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: every array write must match the next expected item (R3 R4 R10)
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3/R9 unexpected write", {mem_addr, mem_wdata}, 0);
      end else begin
        logic [20:0] e;
        e = exp_q.pop_front();
        chk({mem_addr, mem_wdata} == e, "R3 write addr/data", {mem_addr, mem_wdata}, e);
      end
    end
  end

  task automatic ld(input logic [4:0] idx, input logic [7:0] d, input bit model);
    @(negedge clk);
    load_en = 1'b1; load_idx = idx; load_data = d;
    if (model) begin m_data[idx] = d; m_fill[idx] = 1'b1; end
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic commit(input logic [7:0] pg, input bit wpv, input string req);
    bit active, locked;
    int n;
    active = (m_fill != 0);
    locked = wpv && (pg[7:6] == 2'b11);
    @(negedge clk);
    commit_req = 1'b1; page_sel = pg; wp = wpv;
    if (active && !locked)
      for (int i = 0; i < 32; i++)
        if (m_fill[i]) exp_q.push_back({pg, 5'(i), m_data[i]});
    @(negedge clk);
    commit_req = 1'b0;
    chk(busy == active, {req, " busy after request"}, busy, active);
    if (active) begin
      n = 1;
      // R7: stray traffic during busy
      load_en = 1'b1; load_idx = 5'd9; load_data = 8'hEE; commit_req = 1'b1;
      while (1) begin
        @(negedge clk);
        load_en = 1'b0; commit_req = 1'b0;
        if (busy) n++; else break;
        if (n > CYC + 10) break;
      end
      chk(n == CYC, "R5 busy length", n, CYC);
      m_fill = '0;
    end else begin
      repeat (5) @(negedge clk);
      chk(!busy, "R8 empty commit stays idle", busy, 0);
    end
    chk(exp_q.size() == 0, {req, " all writes seen"}, exp_q.size(), 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !mem_we, "R1 reset state", {busy, mem_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_we, "R1 idle after reset", {busy, mem_we}, 0);

    // R2 R3: full page
    for (int i = 0; i < 32; i++) ld(5'(i), 8'(8'h40 + i), 1'b1);
    commit(8'h05, 1'b0, "R2 full page");

    // R3: sparse page
    ld(5'd31, 8'hA1, 1'b1); ld(5'd3, 8'hA2, 1'b1); ld(5'd7, 8'hA3, 1'b1);
    commit(8'h10, 1'b0, "R3 sparse page");

    // R4: repeated positions, wrap past 32 loads
    for (int i = 0; i < 34; i++) ld(5'(i), 8'(i), 1'b1);
    ld(5'd2, 8'h5C, 1'b1);
    commit(8'h22, 1'b0, "R4 last value wins");

    // R6 R7: only a byte loaded after the previous cycle is written
    ld(5'd0, 8'h77, 1'b1);
    commit(8'h33, 1'b0, "R6/R7 mask cleared, busy input ignored");

    // R8: empty commit
    commit(8'h44, 1'b0, "R8 empty");

    // R9: protected page dropped, busy still full
    ld(5'd4, 8'h99, 1'b1); ld(5'd5, 8'h98, 1'b1);
    commit(8'hC0, 1'b1, "R9 locked page");
    ld(5'd1, 8'h11, 1'b1);
    commit(8'hFF, 1'b1, "R9 top page locked");

    // R10: protection off, or page below top quarter
    ld(5'd6, 8'h66, 1'b1);
    commit(8'hBF, 1'b1, "R10 unlocked page wp high");
    ld(5'd30, 8'h3C, 1'b1);
    commit(8'hFF, 1'b0, "R10 top page wp low");

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule